// File: doc/BRIEF.md
# Two-Register ALU Datapath

This block is a narrow datapath with two working registers, A and B, and one combinational function unit. Each register takes its next value from its own four-way source selector. The selector can pick the external input bus, register A, register B, or the function unit's result bus. The function unit drives the shared output bus with one of eight operations on the current register contents:

- pass A or pass B;
- complement of A;
- bitwise AND or OR;
- add with carry-in;
- shift left or logical shift right.

The result bus feeds back into both source selectors. A single clock edge can therefore do a move, an arithmetic step or a shift, and either register can capture the result. An external sequencer drives the select lines every cycle; this block does no instruction decoding. A carry flag register keeps the carry produced by the adder. It changes only when an add result is written into register A. All state clears through an active-low asynchronous reset.

Top module: `dual_reg_alu`

## Requirements
- R1: While rstN is low, register A, register B and the carry flag are all zero, whatever the clock is doing.
- R2: A source select of 00 (selA for A, selB for B) loads that register from inBus on the next rising clock edge.
- R3: A source select of 01 makes the register take A's value, and 10 makes it take B's value. So selA=01 and selB=10 each hold their register, selB=01 copies A into B, and selA=10 copies B into A.
- R4: A source select of 11 loads that register from the value outBus had just before the edge.
- R5: fnSel 000 drives A onto outBus, and fnSel 001 drives B onto outBus.
- R6: fnSel 010 drives the bitwise complement of A, 011 drives A AND B, and 100 drives A OR B.
- R7: fnSel 101 drives the low W bits of A + B + carryIn.
- R8: fnSel 110 drives A shifted left by one with a zero entering bit 0. fnSel 111 drives A shifted right by one with a zero entering the top bit.
- R9: The carry flag takes bit W of A + B + carryIn at an edge where fnSel is 101 and selA is 11. At every other edge it keeps its value.
- R10: Both registers sample the values from before the edge, so selA=10 with selB=01 exchanges A and B in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inBus | input | W | External data bus |
| selA | input | 2 | Source select for register A |
| selB | input | 2 | Source select for register B |
| fnSel | input | 3 | Function select for outBus |
| carryIn | input | 1 | Carry into the adder |
| outBus | output | W | Function unit result |
| regAOut | output | W | Contents of register A |
| regBOut | output | W | Contents of register B |
| carryOut | output | 1 | Stored carry flag |

## Verification
The carry flag is the hardest state to reach and observe. Its update needs two conditions at once: the add function is selected and register A captures the result bus. Its hold behaviour only shows if the flag already holds a value that the adder would overwrite.

The bench sweeps every pair of register values, every function and both carry-in values. Each pair is loaded through the input bus, and then each function's result is written back into both registers. The expected flag is tracked across the whole sequence, so edges that must not touch the flag come right after edges that set it to 1.

// File: rtl/dual_reg_alu_pkg.sv
package dual_reg_alu_pkg;

  typedef enum logic [1:0] {
    SRC_IN  = 2'b00,
    SRC_A   = 2'b01,
    SRC_B   = 2'b10,
    SRC_OUT = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    FN_PASSA = 3'b000,
    FN_PASSB = 3'b001,
    FN_NOTA  = 3'b010,
    FN_AND   = 3'b011,
    FN_OR    = 3'b100,
    FN_ADD   = 3'b101,
    FN_SHL   = 3'b110,
    FN_SHR   = 3'b111
  } fn_e;

  localparam int NUM_REGS = 2;

  typedef struct packed {
    src_e aSrc;
    src_e bSrc;
    fn_e  fn;
    logic carryWe;
  } strobe_t;

endpackage

// File: rtl/dual_reg_alu_ctrl.sv
module dual_reg_alu_ctrl
  import dual_reg_alu_pkg::*;
(
  input  logic [1:0] selA,
  input  logic [1:0] selB,
  input  logic [2:0] fnSel,
  output strobe_t    strobes
);

  always_comb begin
    strobes.aSrc    = src_e'(selA);
    strobes.bSrc    = src_e'(selB);
    strobes.fn      = fn_e'(fnSel);
    // flag follows the adder only when its result lands in register A
    strobes.carryWe = (fn_e'(fnSel) == FN_ADD) && (src_e'(selA) == SRC_OUT);
  end

endmodule

// File: rtl/dual_reg_alu_slot.sv
module dual_reg_alu_slot
  import dual_reg_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  src_e         src,
  input  logic [W-1:0] inVal,
  input  logic [W-1:0] aVal,
  input  logic [W-1:0] bVal,
  input  logic [W-1:0] resVal,
  output logic [W-1:0] q
);

  logic [W-1:0] dNext;

  always_comb begin
    unique case (src)
      SRC_IN:  dNext = inVal;
      SRC_A:   dNext = aVal;
      SRC_B:   dNext = bVal;
      default: dNext = resVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= dNext;
  end

endmodule

// File: rtl/dual_reg_alu_datapath.sv
module dual_reg_alu_datapath
  import dual_reg_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobes,
  input  logic [W-1:0] inBus,
  input  logic         carryIn,
  output logic [W-1:0] resBus,
  output logic [W-1:0] regA,
  output logic [W-1:0] regB,
  output logic         carryQ
);

  localparam int SW = W + 1;

  logic [SW-1:0] sumWide;
  logic [W-1:0]  regArr [NUM_REGS];
  src_e          srcArr [NUM_REGS];

  assign sumWide = {1'b0, regA} + {1'b0, regB} + {{W{1'b0}}, carryIn};

  always_comb begin
    unique case (strobes.fn)
      FN_PASSA: resBus = regA;
      FN_PASSB: resBus = regB;
      FN_NOTA:  resBus = ~regA;
      FN_AND:   resBus = regA & regB;
      FN_OR:    resBus = regA | regB;
      FN_ADD:   resBus = sumWide[W-1:0];
      FN_SHL:   resBus = {regA[W-2:0], 1'b0};
      default:  resBus = {1'b0, regA[W-1:1]};
    endcase
  end

  assign srcArr[0] = strobes.aSrc;
  assign srcArr[1] = strobes.bSrc;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    dual_reg_alu_slot #(.W(W)) u_slot (
      .clk    (clk),
      .rstN   (rstN),
      .src    (srcArr[i]),
      .inVal  (inBus),
      .aVal   (regA),
      .bVal   (regB),
      .resVal (resBus),
      .q      (regArr[i])
    );
  end

  assign regA = regArr[0];
  assign regB = regArr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                carryQ <= 1'b0;
    else if (strobes.carryWe) carryQ <= sumWide[W];
  end

endmodule

// File: rtl/dual_reg_alu.sv
module dual_reg_alu
  import dual_reg_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] inBus,
  input  logic [1:0]   selA,
  input  logic [1:0]   selB,
  input  logic [2:0]   fnSel,
  input  logic         carryIn,
  output logic [W-1:0] outBus,
  output logic [W-1:0] regAOut,
  output logic [W-1:0] regBOut,
  output logic         carryOut
);

  strobe_t strobes;

  dual_reg_alu_ctrl u_ctrl (
    .selA    (selA),
    .selB    (selB),
    .fnSel   (fnSel),
    .strobes (strobes)
  );

  dual_reg_alu_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inBus   (inBus),
    .carryIn (carryIn),
    .resBus  (outBus),
    .regA    (regAOut),
    .regB    (regBOut),
    .carryQ  (carryOut)
  );

endmodule

// File: rtl/dual_reg_alu_checks.sv
module dual_reg_alu_checks #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] inBus,
  input logic [1:0]   selA,
  input logic [1:0]   selB,
  input logic [2:0]   fnSel,
  input logic         carryIn,
  input logic [W-1:0] outBus,
  input logic [W-1:0] regAOut,
  input logic [W-1:0] regBOut,
  input logic         carryOut
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (regAOut == '0 && regBOut == '0 && !carryOut)); // R1

  AST_LOAD_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    selA == 2'b00 |=> regAOut == $past(inBus)); // R2

  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    selA == 2'b01 |=> $stable(regAOut)); // R3

  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    selB == 2'b10 |=> $stable(regBOut)); // R3

  AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    selB == 2'b11 |=> regBOut == $past(outBus)); // R4

  AST_PASS_A: assert property (@(posedge clk) disable iff (!rstN)
    fnSel == 3'b000 |-> outBus == regAOut); // R5

  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !(fnSel == 3'b101 && selA == 2'b11) |=> $stable(carryOut)); // R9

  AST_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (selA == 2'b10 && selB == 2'b01) |=>
      (regAOut == $past(regBOut) && regBOut == $past(regAOut))); // R10

endmodule

bind dual_reg_alu dual_reg_alu_checks #(.W(W)) u_checks (.*);

// File: tb/dual_reg_alu_tb.sv
module dual_reg_alu_tb;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] inBus = '0;
  logic [1:0]   selA = 2'b01;
  logic [1:0]   selB = 2'b10;
  logic [2:0]   fnSel = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] outBus, regAOut, regBOut;
  logic         carryOut;

  int errors = 0;
  int checks = 0;
  bit expCarry = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_reg_alu #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .inBus(inBus), .selA(selA), .selB(selB),
    .fnSel(fnSel), .carryIn(carryIn), .outBus(outBus), .regAOut(regAOut),
    .regBOut(regBOut), .carryOut(carryOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic int model(int f, int a, int b, int c);
    case (f)
      0: return a;
      1: return b;
      2: return (~a) & MASK;
      3: return a & b;
      4: return a | b;
      5: return (a + b + c) & MASK;
      6: return (a << 1) & MASK;
      default: return a >> 1;
    endcase
  endfunction

  task automatic loadAB(int a, int b);
    inBus = W'(b); selA = 2'b00; selB = 2'b00; tick();
    inBus = W'(a); selA = 2'b00; selB = 2'b10; tick();
    selA = 2'b01;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    check("R1 A in reset", int'(regAOut), 0);
    check("R1 B in reset", int'(regBOut), 0);
    check("R1 carry in reset", int'(carryOut), 0);
    rstN = 1'b1;
    tick();

    // R2 / R3: load, hold, cross copies, swap (R10)
    loadAB(4'h9, 4'h3);
    check("R2 load A", int'(regAOut), 9);
    check("R2 load B", int'(regBOut), 3);
    inBus = 4'hF; selA = 2'b01; selB = 2'b10; tick();
    check("R3 hold A", int'(regAOut), 9);
    check("R3 hold B", int'(regBOut), 3);
    selA = 2'b10; selB = 2'b01; tick();
    check("R10 swap A", int'(regAOut), 3);
    check("R10 swap B", int'(regBOut), 9);
    selA = 2'b01; selB = 2'b01; tick();
    check("R3 B copies A", int'(regBOut), 3);
    loadAB(4'h6, 4'hC);
    selA = 2'b10; selB = 2'b10; tick();
    check("R3 A copies B", int'(regAOut), 12);

    // exhaustive function sweep with write-back to both registers
    for (int a = 0; a <= MASK; a++) begin
      for (int b = 0; b <= MASK; b++) begin
        for (int f = 0; f < 8; f++) begin
          for (int c = 0; c < 2; c++) begin
            int exp;
            loadAB(a, b);
            fnSel = 3'(f); carryIn = c[0]; #1;
            exp = model(f, a, b, c);
            if (f == 0 || f == 1) check("R5 pass", int'(outBus), exp);
            else if (f >= 2 && f <= 4) check("R6 logic", int'(outBus), exp);
            else if (f == 5) check("R7 add", int'(outBus), exp);
            else check("R8 shift", int'(outBus), exp);
            selA = 2'b11; selB = 2'b11; tick();
            if (f == 5) expCarry = ((a + b + c) > MASK);
            check("R4 A takes result", int'(regAOut), exp);
            check("R4 B takes result", int'(regBOut), exp);
            check("R9 carry flag", int'(carryOut), int'(expCarry));
            // add selected but result only into B: flag must keep value
            loadAB(MASK, 1);
            fnSel = 3'b101; carryIn = 1'b0; selA = 2'b01; selB = 2'b11; tick();
            check("R9 carry keep", int'(carryOut), int'(expCarry));
            selB = 2'b10;
          end
        end
      end
    end

    // R1: asynchronous reset mid-run, away from a clock edge
    loadAB(4'h5, 4'hA);
    #2 rstN = 1'b0; #1;
    check("R1 async A", int'(regAOut), 0);
    check("R1 async B", int'(regBOut), 0);
    check("R1 async carry", int'(carryOut), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule